// File: doc/BRIEF.md
# Numbered-Field Instruction Executor

This block runs a short program in which every operand names a numbered data field instead of a memory address. The fields live in a small local register file, eight 16-bit fields by default. The program lives in a small instruction store. The store is filled through a write port while execution is paused. When `run` is high, the block retires one instruction per clock. In that one cycle it fetches the instruction at the program counter, resolves the source and destination operands, applies the operation and updates the program counter.

Each operand has its own addressing mode. A constant carries its value in the operand itself. A direct operand names a field. An indirect operand names a field whose contents name another field. Copy and the four arithmetic operations write the destination field. A jump moves the program counter by a signed offset relative to the current instruction, so an offset of minus one makes a two-instruction loop. Faults never stop execution. A divide by zero, a constant destination, a reserved mode or the unused opcode each cancel the field write and latch an error flag.

A `peek` port reads any field combinationally, which lets the surrounding logic observe the results.

Top module: `dfx_core`

## Requirements
- R1: While `rst_n` is low, and after it rises, the program counter is 0, every field is 0 and `err` is 0.
- R2: While `load_en` is high, `load_instr` is written to instruction slot `load_addr` and no instruction executes. While `run` is low, the program counter and all fields hold.
- R3: An instruction is 23 bits. From the top down they are: opcode [22:20], source mode [19:18], source operand [17:10], destination mode [9:8], destination operand [7:0]. Opcode codes are 0 no-op, 1 copy, 2 add, 3 subtract, 4 multiply, 5 divide, 6 jump and 7 unused. Mode codes are 0 constant, 1 direct, 2 indirect and 3 reserved.
- R4: A copy whose source is a constant writes the 8-bit source operand, zero-extended to 16 bits, into the destination field.
- R5: A direct source reads field (operand mod 8). An indirect source reads field (F mod 8), where F is the contents of field (operand mod 8).
- R6: A direct destination is field (operand mod 8). An indirect destination is field (F mod 8), where F is the contents of field (operand mod 8).
- R7: Add, subtract and multiply compute destination = destination op source, unsigned and modulo 2^16. Multiply keeps the low 16 bits of the product.
- R8: Divide writes the unsigned quotient destination / source. A zero divisor leaves the destination unchanged and sets `err`.
- R9: A jump adds the source operand, read as a signed 8-bit value, to the program counter modulo 16. It writes no field. An offset of -1 returns to the preceding instruction.
- R10: Every instruction other than a jump advances the program counter by one modulo 16, including no-ops and faulting instructions. One instruction retires per cycle while `run` is high and `load_en` is low.
- R11: The instruction writes no field and sets `err` in any of these cases: opcode 7; an operation 1 to 5 whose destination mode is constant or reserved; an operation 1 to 5 whose source mode is reserved.
- R12: `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en | input | 1 | Write `load_instr` into the instruction store; suppresses execution |
| load_addr | input | 4 | Instruction slot to write |
| load_instr | input | 23 | Instruction word to store |
| run | input | 1 | Retire one instruction this cycle |
| peek_sel | input | 3 | Field number to observe |
| peek_data | output | 16 | Contents of field `peek_sel` |
| pc | output | 4 | Program counter |
| err | output | 1 | Sticky fault flag |

## Verification
The assertions take for granted that every instruction slot is written before `run` is first raised. The instruction store has no reset, so an unwritten slot would be fetched as an unknown word. The bench therefore loads all sixteen slots of each program, filling unused slots with no-ops, before it starts execution. It stops `run` before any further reload. The stimulus also reaches every mode combination only through whole, well-formed 23-bit words. This keeps the operand fields and the program counter free of unknown values under every property.

// File: rtl/dfx_pkg.sv
package dfx_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_COPY = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_JUMP = 3'd6,
    OP_BAD  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    AM_CONST    = 2'd0,
    AM_DIRECT   = 2'd1,
    AM_INDIRECT = 2'd2,
    AM_RSVD     = 2'd3
  } amode_e;

endpackage

// File: rtl/dfx_progmem.sv
module dfx_progmem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 23,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  // storage array, written only through the load port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dfx_fieldfile.sv
module dfx_fieldfile #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] fields
);

  logic [N-1:0][W-1:0] fields_q;
  logic [N-1:0][W-1:0] fields_d;

  always_comb begin
    fields_d = fields_q;
    if (we) begin
      fields_d[waddr] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (we) begin
      fields_q <= fields_d;
    end
  end

  assign fields = fields_q;

  // a granted write lands in the addressed field on the next edge
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> fields_q[$past(waddr)] == $past(wdata));

  // nothing moves in the file without a write grant
  assert_no_write_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(fields_q));

endmodule

// File: rtl/dfx_operand.sv
module dfx_operand
  import dfx_pkg::*;
#(
  parameter int N       = 8,
  parameter int W       = 16,
  parameter int OW      = 8,
  parameter bit IS_DEST = 1'b0,
  localparam int IW = $clog2(N)
) (
  input  amode_e              mode,
  input  logic [OW-1:0]       opnd,
  input  logic [N-1:0][W-1:0] fields,
  output logic [IW-1:0]       idx,
  output logic [W-1:0]        val,
  output logic                ok
);

  logic [IW-1:0] ptr;
  assign ptr = opnd[IW-1:0];

  always_comb begin
    unique case (mode)
      AM_INDIRECT: idx = fields[ptr][IW-1:0];
      default:     idx = ptr;
    endcase
  end

  generate
    if (IS_DEST) begin : g_dest
      assign ok  = (mode == AM_DIRECT) || (mode == AM_INDIRECT);
      assign val = fields[idx];
    end else begin : g_src
      assign ok  = (mode != AM_RSVD);
      assign val = (mode == AM_CONST) ? W'(opnd) : fields[idx];
    end
  endgenerate

endmodule

// File: rtl/dfx_alu.sv
module dfx_alu
  import dfx_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] dst_val,
  input  logic [W-1:0] src_val,
  output logic [W-1:0] res,
  output logic         arith,
  output logic         div_zero
);

  logic [2*W-1:0] prod;
  assign prod = (2*W)'(dst_val) * (2*W)'(src_val);

  always_comb begin
    res      = src_val;
    arith    = 1'b1;
    div_zero = 1'b0;
    unique case (op)
      OP_COPY: res = src_val;
      OP_ADD:  res = dst_val + src_val;
      OP_SUB:  res = dst_val - src_val;
      OP_MUL:  res = prod[W-1:0];
      OP_DIV: begin
        if (src_val == '0) begin
          div_zero = 1'b1;
          res      = dst_val;
        end else begin
          res = dst_val / src_val;
        end
      end
      default: arith = 1'b0;
    endcase
  end

endmodule

// File: rtl/dfx_core.sv
module dfx_core
  import dfx_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int DATA_W     = 16,
  parameter int OPND_W     = 8,
  parameter int PROG_DEPTH = 16,
  localparam int IDX_W   = $clog2(NUM_FIELDS),
  localparam int PC_W    = $clog2(PROG_DEPTH),
  localparam int INSTR_W = 2 * OPND_W + 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [PC_W-1:0]    load_addr,
  input  logic [INSTR_W-1:0] load_instr,
  input  logic               run,
  input  logic [IDX_W-1:0]   peek_sel,
  output logic [DATA_W-1:0]  peek_data,
  output logic [PC_W-1:0]    pc,
  output logic               err
);

  logic [PC_W-1:0]    pc_q, pc_d;
  logic               err_q, err_d;
  logic [INSTR_W-1:0] instr;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fields;

  op_e                op;
  amode_e             smode, dmode;
  logic [OPND_W-1:0]  sopnd, dopnd;
  logic signed [OPND_W-1:0] jump_off;

  logic [IDX_W-1:0]   src_idx, dst_idx;
  logic [DATA_W-1:0]  src_val, dst_val, alu_res;
  logic               src_ok, dst_ok, alu_arith, div_zero;
  logic               step, is_jump, fault, we;

  // instruction store
  dfx_progmem #(.DEPTH(PROG_DEPTH), .WIDTH(INSTR_W)) u_prog (
    .clk     (clk),
    .wr_en   (load_en),
    .wr_addr (load_addr),
    .wr_data (load_instr),
    .rd_addr (pc_q),
    .rd_data (instr)
  );

  // field decode, opcode in the top bits
  assign op       = op_e'(instr[INSTR_W-1 -: 3]);
  assign smode    = amode_e'(instr[INSTR_W-4 -: 2]);
  assign sopnd    = instr[INSTR_W-6 -: OPND_W];
  assign dmode    = amode_e'(instr[OPND_W+1 -: 2]);
  assign dopnd    = instr[OPND_W-1:0];
  assign jump_off = $signed(sopnd);

  dfx_operand #(.N(NUM_FIELDS), .W(DATA_W), .OW(OPND_W), .IS_DEST(1'b0)) u_src (
    .mode   (smode),
    .opnd   (sopnd),
    .fields (fields),
    .idx    (src_idx),
    .val    (src_val),
    .ok     (src_ok)
  );

  dfx_operand #(.N(NUM_FIELDS), .W(DATA_W), .OW(OPND_W), .IS_DEST(1'b1)) u_dst (
    .mode   (dmode),
    .opnd   (dopnd),
    .fields (fields),
    .idx    (dst_idx),
    .val    (dst_val),
    .ok     (dst_ok)
  );

  dfx_alu #(.W(DATA_W)) u_alu (
    .op       (op),
    .dst_val  (dst_val),
    .src_val  (src_val),
    .res      (alu_res),
    .arith    (alu_arith),
    .div_zero (div_zero)
  );

  // execution control
  assign step    = run & ~load_en;
  assign is_jump = (op == OP_JUMP);
  assign we      = step & alu_arith & src_ok & dst_ok & ~div_zero;
  assign fault   = step & ((op == OP_BAD) |
                           (alu_arith & ~(src_ok & dst_ok)) |
                           (alu_arith & src_ok & dst_ok & div_zero));

  dfx_fieldfile #(.N(NUM_FIELDS), .W(DATA_W)) u_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .waddr  (dst_idx),
    .wdata  (alu_res),
    .fields (fields)
  );

  always_comb begin
    pc_d  = pc_q;
    err_d = err_q | fault;
    if (step) begin
      if (is_jump) begin
        pc_d = pc_q + PC_W'(jump_off);
      end else begin
        pc_d = pc_q + PC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_d;
    end
  end

  assign pc        = pc_q;
  assign err       = err_q;
  assign peek_data = fields[peek_sel];

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && !load_en) |=> $stable(pc_q));

  assert_nonjump_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_en && op != OP_JUMP) |=> pc_q == PC_W'($past(pc_q) + PC_W'(1)));

  assert_jump_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == OP_JUMP) |-> !we);

  assert_divzero_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == OP_DIV && src_ok && dst_ok && src_val == '0) |=> err_q);

  assert_bad_dest_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op inside {OP_COPY, OP_ADD, OP_SUB, OP_MUL, OP_DIV} &&
     !(dmode inside {AM_DIRECT, AM_INDIRECT})) |=> err_q);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: tb/dfx_core_bench.sv
`timescale 1ns/1ps
module dfx_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [3:0]  load_addr;
  logic [22:0] load_instr;
  logic        run;
  logic [2:0]  peek_sel;
  logic [15:0] peek_data;
  logic [3:0]  pc;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_pc, m_err;
  int m_f [8];
  logic [22:0] m_prog [16];
  logic [22:0] prg [16];

  always #2.5 clk = ~clk;

  dfx_core u_dfx_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_instr(load_instr), .run(run), .peek_sel(peek_sel),
    .peek_data(peek_data), .pc(pc), .err(err)
  );

  // R3 layout: op[22:20] smode[19:18] sopnd[17:10] dmode[9:8] dopnd[7:0]
  function automatic logic [22:0] enc(int op, int sm, int so, int dm, int dd);
    return {op[2:0], sm[1:0], so[7:0], dm[1:0], dd[7:0]};
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // behavioural model, one instruction per enabled edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_err = 0;
      foreach (m_f[i]) m_f[i] = 0;
    end else if (load_en) begin
      m_prog[load_addr] = load_instr;
    end else if (run) begin
      logic [22:0] w;
      int op, sm, so, dm, dd, sv, di, ok, res, off;
      w = m_prog[m_pc];
      op = int'(w[22:20]); sm = int'(w[19:18]); so = int'(w[17:10]);
      dm = int'(w[9:8]); dd = int'(w[7:0]);
      ok = 1; sv = 0; di = 0;
      if (sm == 0) sv = so;
      else if (sm == 1) sv = m_f[so % 8];
      else if (sm == 2) sv = m_f[m_f[so % 8] % 8];
      else ok = 0;
      if (dm == 1) di = dd % 8;
      else if (dm == 2) di = m_f[dd % 8] % 8;
      else ok = 0;
      if (op == 6) begin
        off = (so >= 128) ? so - 256 : so;
        m_pc = ((m_pc + off) % 16 + 16) % 16;
      end else begin
        m_pc = (m_pc + 1) % 16;
        if (op == 7) m_err = 1;
        else if (op >= 1 && op <= 5) begin
          if (ok == 0) m_err = 1;
          else if (op == 5 && sv == 0) m_err = 1;
          else begin
            case (op)
              1: res = sv;
              2: res = m_f[di] + sv;
              3: res = m_f[di] - sv;
              4: res = int'((longint'(m_f[di]) * longint'(sv)) & 64'hFFFF);
              default: res = m_f[di] / sv;
            endcase
            m_f[di] = res & 16'hFFFF;
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_req, "pc", int'(pc), m_pc);
      chk(cur_req, "err", int'(err), m_err);
      for (int i = 0; i < 8; i++) begin
        peek_sel = 3'(i);
        #0.1;
        chk(cur_req, $sformatf("field%0d", i), int'(peek_data), m_f[i]);
      end
    end
  end

  task automatic peek(int idx, output int v);
    peek_sel = 3'(idx);
    #0.1;
    v = int'(peek_data);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; run = 1'b0; load_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic load_prog();
    cur_req = "R2";
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 4'(i); load_instr = prg[i];
    end
    @(negedge clk); load_en = 1'b0;
  endtask

  // retire n instructions, then leave a stable window for explicit checks
  task automatic exec(int n, string tag);
    cur_req = tag;
    @(negedge clk); run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
    #1.5;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prg[i] = enc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; run = 1'b0; load_en = 1'b0;
    load_addr = '0; load_instr = '0; peek_sel = '0;
    repeat (3) @(negedge clk);
    #1.0;
    // R1: values held in reset
    chk("R1", "pc in reset", int'(pc), 0);
    chk("R1", "err in reset", int'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    #1.5;
    peek(5, v); chk("R1", "field5 after reset", v, 0);
    cmp_on = 1'b1;

    // program A: counter loop
    clear_prog();
    prg[0] = enc(1, 0, 0, 1, 0);
    prg[1] = enc(1, 0, 5, 1, 1);
    prg[2] = enc(2, 1, 1, 1, 0);
    prg[3] = enc(6, 0, 8'hFF, 0, 0);
    load_prog();
    #1.5;
    chk("R2", "pc during load", int'(pc), 0);
    exec(2, "R4");
    peek(1, v); chk("R4", "constant copy f1", v, 5);
    exec(6, "R9");
    peek(0, v); chk("R9", "loop sum f0", v, 15);
    chk("R9", "pc after loop", int'(pc), 2);
    cur_req = "R2";
    repeat (3) @(negedge clk);
    #1.5;
    chk("R2", "pc hold run low", int'(pc), 2);
    @(negedge clk); run = 1'b1; load_en = 1'b1; load_addr = 4'd15; load_instr = enc(0,0,0,0,0);
    @(negedge clk); run = 1'b0; load_en = 1'b0;
    #1.5;
    chk("R2", "pc hold during load", int'(pc), 2);
    peek(0, v); chk("R2", "f0 hold during load", v, 15);

    // program B: modes, arithmetic, faults, jump skip
    do_reset();
    clear_prog();
    prg[0]  = enc(1, 0, 3, 1, 2);
    prg[1]  = enc(1, 0, 200, 1, 3);
    prg[2]  = enc(1, 2, 2, 1, 4);
    prg[3]  = enc(1, 0, 7, 2, 2);
    prg[4]  = enc(3, 1, 3, 1, 4);
    prg[5]  = enc(1, 0, 255, 1, 5);
    prg[6]  = enc(4, 1, 5, 1, 5);
    prg[7]  = enc(4, 1, 5, 1, 5);
    prg[8]  = enc(3, 1, 4, 1, 2);
    prg[9]  = enc(5, 0, 10, 1, 4);
    prg[10] = enc(5, 1, 0, 1, 4);
    prg[11] = enc(1, 0, 9, 0, 6);
    prg[12] = enc(6, 0, 2, 0, 0);
    prg[13] = enc(1, 0, 1, 1, 7);
    prg[14] = enc(0, 0, 0, 0, 0);
    prg[15] = enc(2, 3, 0, 1, 6);
    load_prog();
    exec(3, "R5");
    peek(4, v); chk("R5", "indirect source f4", v, 200);
    exec(1, "R6");
    peek(3, v); chk("R6", "indirect dest f3", v, 7);
    exec(2, "R7");
    peek(4, v); chk("R7", "subtract f4", v, 193);
    peek(5, v); chk("R3", "operand field decode f5", v, 255);
    exec(2, "R7");
    peek(5, v); chk("R7", "multiply low half f5", v, 64513);
    exec(1, "R7");
    peek(2, v); chk("R7", "subtract wrap f2", v, 65346);
    exec(1, "R8");
    peek(4, v); chk("R8", "quotient f4", v, 19);
    chk("R8", "err before zero divide", int'(err), 0);
    exec(1, "R8");
    peek(4, v); chk("R8", "zero divide keeps f4", v, 19);
    chk("R8", "zero divide err", int'(err), 1);
    exec(1, "R11");
    peek(6, v); chk("R11", "const dest no write f6", v, 0);
    exec(1, "R9");
    chk("R9", "jump forward pc", int'(pc), 14);
    exec(2, "R10");
    chk("R10", "wrap to pc 0", int'(pc), 0);
    peek(7, v); chk("R9", "skipped slot f7", v, 0);
    peek(6, v); chk("R11", "reserved src no write f6", v, 0);

    // program C: faults on a clean flag
    do_reset();
    clear_prog();
    prg[0] = enc(7, 1, 1, 1, 1);
    prg[2] = enc(1, 0, 4, 3, 1);
    load_prog();
    exec(1, "R11");
    chk("R11", "opcode 7 err", int'(err), 1);
    chk("R10", "pc after faulting op", int'(pc), 1);
    exec(5, "R12");
    chk("R12", "err sticky", int'(err), 1);
    peek(1, v); chk("R11", "reserved dest no write f1", v, 0);
    do_reset();
    #1.5;
    chk("R12", "err cleared by reset", int'(err), 0);
    exec(3, "R11");
    chk("R11", "reserved dest err", int'(err), 1);

    cmp_on = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule